// File: doc/BRIEF.md
# Successive-Approximation Converter Register Interface

This block is the digital side of a four-input, 9-bit successive-approximation converter. Software reaches it through a byte-wide register bus at four addresses. Those addresses hold the control word, the conversion-clock selection and the two read-only halves of the result. From the control word the block derives which port pins are switched to analog use, which input the multiplexer passes and whether the analog section needs power.

A conversion is launched by a complete pulse on the START bit. START is first written to 1, which sets the busy flag (EOC, active high while busy). START is then written back to 0, and the sequencer begins. The sequencer drives a trial code to an external DAC and reads an external comparator, one bit per conversion-clock tick, most significant bit first. After nine ticks it stores the result, clears EOC and raises a one-cycle interrupt request when interrupts are enabled.

Writing START to 1 again while a conversion runs abandons that conversion and re-arms the flag. The conversion clock is the system clock divided by 1, 2, 4 or 8.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset every register reads 0x00, `ana_en` is 0000, `adc_pwr` is 0, `dac_code` is 0 and `irq_req` is 0.
- R2: Address 0x24 reads the low result byte, 0x25 the high result byte, 0x26 the control word and 0x27 the clock-select word. Any other address reads 0x00, and writes to 0x24 or 0x25 change nothing.
- R3: Control bits 5:0 read back as written. In the clock-select word, bits 1:0 and bit 7 read back as written and bits 6:2 read 0.
- R4: Writing control bit 7 (START) from 0 to 1 sets control bit 6 (EOC) to 1 at that write edge. Software writes to bit 6 are ignored.
- R5: A START rise alone begins no conversion: `dac_code` stays 0 and EOC stays 1. The conversion begins on the write that returns START from 1 to 0, and the first trial code is 0x100.
- R6: The sequencer decides bits 8 down to 0 in turn and keeps a bit when `cmp_in` is 1 (analog level at or above the trial code). For a comparator that reports `level >= dac_code`, the stored result equals `level`.
- R7: Clock-select bits 1:0 = s give a tick every 2^s system clocks. EOC falls exactly 9·2^s clocks after the edge that took the START-falling write.
- R8: Clock-select bit 7 has no effect on conversion timing or result.
- R9: At completion EOC returns to 0 on the same edge that stores the result. `irq_req` is high for exactly the following cycle when `irq_en` is 1, and stays 0 when `irq_en` is 0.
- R10: The result is left-justified: byte 0x25 holds result bits 8:1, bit 7 of byte 0x24 holds result bit 0, and bits 6:0 of 0x24 read 0.
- R11: Control bits 5:3 = c drive `ana_en`: 000 gives 0000, 001 gives 0001, 010 gives 0011, 011 gives 0111 and 1xx gives 1111. `adc_pwr` is 1 whenever any pin is analog.
- R12: `ch_sel` equals control bits 1:0. Control bit 2 is stored but does not affect `ch_sel`.
- R13: A START rise during a conversion aborts it. EOC stays 1, `dac_code` returns to 0, the previous result is kept and no interrupt is raised. The next START fall runs a complete conversion of full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmp_in | input | 1 | Comparator output: 1 when the analog level is at or above `dac_code` |
| irq_en | input | 1 | Converter interrupt enable |
| dac_code | output | 9 | Trial code for the DAC; 0 while idle |
| ch_sel | output | 2 | Analog input multiplexer select |
| ana_en | output | 4 | Per-pin analog enable; 1 disables digital I/O and pull-high on that pin |
| adc_pwr | output | 1 | Analog section power enable |
| irq_req | output | 1 | One-cycle conversion-complete interrupt request |

## Verification
The comparator is modelled as a level compared against `dac_code`. Every level from 0 to 511 is converted at the fastest clock, so that each result bit is shown to be kept and dropped under every pattern of higher bits, and any misplaced bit in the left-justified split shows up. Each divider setting is run with the test bit set and clear; this separates a wrong tick rate from a test bit that leaks into timing. All eight configuration codes and all eight channel codes are swept to tell the thermometer decode and the ignored channel bit apart. An abort mid-conversion, followed by a full conversion, distinguishes a clean restart from one that carries over the old bit position or divider phase.

// File: rtl/sar_adc_pkg.sv
// Package: shared constants and types for the converter register interface.
// Assumes a 9-bit result split over two bytes and a four-pin analog port.
package sar_adc_pkg;
    localparam int RES_W     = 9;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int NUM_PINS  = 4;
    localparam int CFG_W     = 3;
    localparam int CH_W      = 2;
    localparam int SEL_W     = 2;
    localparam int IDX_W     = $clog2(RES_W);

    localparam logic [ADDR_W-1:0] A_RES_LO = 8'h24;
    localparam logic [ADDR_W-1:0] A_RES_HI = 8'h25;
    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h26;
    localparam logic [ADDR_W-1:0] A_CLKSEL = 8'h27;

    typedef enum logic {SEQ_IDLE = 1'b0, SEQ_CONV = 1'b1} seq_state_t;
endpackage

// File: rtl/sar_adc_pinmux.sv
// Module: sar_adc_pinmux
// Decodes the 3-bit port configuration into per-pin analog enables.
// A code with its top bit set makes every pin analog. Otherwise the low
// bits give how many of the lowest pins are analog. Power follows any enable.
module sar_adc_pinmux
    import sar_adc_pkg::*;
#(
    parameter int PINS = NUM_PINS
) (
    input  logic [CFG_W-1:0] cfg,
    output logic [PINS-1:0]  ana_en,
    output logic             pwr
);
    localparam int CNT_W = CFG_W - 1;

    // One decode per pin: analog when all-analog or below the count.
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign ana_en[p] = cfg[CFG_W-1] || (p < int'(cfg[CNT_W-1:0]));
    end

    // Power the analog section when any pin is analog.
    assign pwr = |ana_en;
endmodule

// File: rtl/sar_adc_clkdiv.sv
// Module: sar_adc_clkdiv
// Produces the conversion-clock tick as an enable, one every 2^sel clocks.
// Assumes run is low between conversions so that each conversion starts
// from phase zero.
module sar_adc_clkdiv
    import sar_adc_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    localparam int MAX_DIV = 1 << ((1 << SW) - 1);
    localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] div_m1;

    // Terminal count for the selected ratio.
    always_comb div_m1 = CNT_W'((32'd1 << sel) - 32'd1);

    assign tick = run && (cnt_q == div_m1);

    // Phase counter: held at zero while idle, wraps on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div_m1) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sar_adc_seq.sv
// Module: sar_adc_seq
// Successive-approximation sequencer. On go it presents the mid-scale
// trial and then decides one bit per tick, MSB first, keeping a bit when
// the comparator reports the level at or above the trial. Abort has
// priority over every other event and returns the sequencer to idle
// without touching the stored result.
module sar_adc_seq
    import sar_adc_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort,
    input  logic         go,
    input  logic         tick,
    input  logic         cmp_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] result
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    seq_state_t     state_q;
    logic [W-1:0]   trial_q;
    logic [W-1:0]   decided;
    logic [W-1:0]   next_trial;
    logic [IW-1:0]  idx_q;
    logic           last_bit;

    assign busy     = (state_q == SEQ_CONV);
    assign dac_code = trial_q;
    assign last_bit = (idx_q == '0);
    assign done     = busy && tick && last_bit && !abort;

    // Trial update: settle the current bit, then raise the next lower one.
    always_comb begin
        decided = trial_q;
        decided[idx_q] = cmp_in;
        next_trial = decided;
        if (!last_bit) begin
            next_trial[idx_q - 1'b1] = 1'b1;
        end
    end

    // Sequencer state, trial register, bit index and result store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            trial_q <= '0;
            idx_q   <= '0;
            result  <= '0;
        end else if (abort) begin
            state_q <= SEQ_IDLE;
            trial_q <= '0;
            idx_q   <= '0;
        end else if (go) begin
            state_q <= SEQ_CONV;
            trial_q <= W'(1) << (W - 1);
            idx_q   <= IW'(W - 1);
        end else if (busy && tick) begin
            if (last_bit) begin
                state_q <= SEQ_IDLE;
                trial_q <= '0;
                result  <= decided;
            end else begin
                trial_q <= next_trial;
                idx_q   <= idx_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/sar_adc_regs.sv
// Module: sar_adc_regs
// Register file for the converter. It holds the control and clock-select
// words and the EOC flag, and detects START edges from bus writes. It also
// forms read data and the interrupt pulse.
// Assumes one write per bus_wr cycle and a combinational read path.
module sar_adc_regs
    import sar_adc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              irq_en,
    input  logic              done,
    input  logic [RES_W-1:0]  result,
    output logic [5:0]        ctrl_lo,
    output logic [SEL_W-1:0]  clk_sel,
    output logic              start_rise,
    output logic              start_fall,
    output logic              eoc,
    output logic              irq_req
);
    logic       start_q;
    logic       test_q;
    logic       wr_ctrl;
    logic       wr_clk;
    logic [DATA_W-1:0] res_lo_byte;
    logic [DATA_W-1:0] res_hi_byte;

    assign wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
    assign wr_clk     = bus_wr && (bus_addr == A_CLKSEL);
    assign start_rise = wr_ctrl &&  bus_wdata[7] && !start_q;
    assign start_fall = wr_ctrl && !bus_wdata[7] &&  start_q;

    // Left-justified result split into the two read-only bytes.
    assign res_hi_byte = result[RES_W-1:1];
    assign res_lo_byte = {result[0], 7'b0};

    // Control word and START history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_lo <= '0;
            start_q <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_lo <= bus_wdata[5:0];
            start_q <= bus_wdata[7];
        end
    end

    // Clock-select word: divider select and the inert test bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel <= '0;
            test_q  <= 1'b0;
        end else if (wr_clk) begin
            clk_sel <= bus_wdata[SEL_W-1:0];
            test_q  <= bus_wdata[7];
        end
    end

    // EOC flag: set by a START rise, cleared by completion; rise wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc <= 1'b0;
        end else if (start_rise) begin
            eoc <= 1'b1;
        end else if (done) begin
            eoc <= 1'b0;
        end
    end

    // Interrupt request: one cycle after completion when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
        end else begin
            irq_req <= done && irq_en;
        end
    end

    // Read multiplexer over the four addresses.
    always_comb begin
        unique case (bus_addr)
            A_RES_LO: bus_rdata = res_lo_byte;
            A_RES_HI: bus_rdata = res_hi_byte;
            A_CTRL:   bus_rdata = {start_q, eoc, ctrl_lo};
            A_CLKSEL: bus_rdata = {test_q, {(DATA_W-1-SEL_W){1'b0}}, clk_sel};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sar_adc_ctrl.sv
// Module: sar_adc_ctrl (top)
// Digital control for a four-input 9-bit successive-approximation
// converter. It connects the register file, the pin decoder, the tick
// divider and the sequencer. The DAC and comparator are external: dac_code
// goes out and cmp_in comes back in the same cycle.
module sar_adc_ctrl
    import sar_adc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmp_in,
    input  logic              irq_en,
    output logic [RES_W-1:0]  dac_code,
    output logic [CH_W-1:0]   ch_sel,
    output logic [NUM_PINS-1:0] ana_en,
    output logic              adc_pwr,
    output logic              irq_req
);
    logic [5:0]        ctrl_lo;
    logic [SEL_W-1:0]  clk_sel;
    logic              start_rise;
    logic              start_fall;
    logic              eoc;
    logic              done;
    logic              busy;
    logic              tick;
    logic [RES_W-1:0]  result;

    sar_adc_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_en     (irq_en),
        .done       (done),
        .result     (result),
        .ctrl_lo    (ctrl_lo),
        .clk_sel    (clk_sel),
        .start_rise (start_rise),
        .start_fall (start_fall),
        .eoc        (eoc),
        .irq_req    (irq_req)
    );

    sar_adc_pinmux #(.PINS(NUM_PINS)) u_pinmux (
        .cfg    (ctrl_lo[5:3]),
        .ana_en (ana_en),
        .pwr    (adc_pwr)
    );

    sar_adc_clkdiv #(.SW(SEL_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .sel   (clk_sel),
        .tick  (tick)
    );

    sar_adc_seq #(.W(RES_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (start_rise),
        .go       (start_fall),
        .tick     (tick),
        .cmp_in   (cmp_in),
        .busy     (busy),
        .done     (done),
        .dac_code (dac_code),
        .result   (result)
    );

    // Channel select: bit 2 of the control word is stored but unused here.
    assign ch_sel = ctrl_lo[CH_W-1:0];
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
// Module: sar_adc_ctrl_chk
// Temporal checks on the converter interface, bound into the top module.
module sar_adc_ctrl_chk
    import sar_adc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                irq_en,
    input logic                irq_req,
    input logic                eoc,
    input logic                start_rise,
    input logic                start_fall,
    input logic                busy,
    input logic [RES_W-1:0]    dac_code,
    input logic [NUM_PINS-1:0] ana_en,
    input logic                adc_pwr,
    input logic [RES_W-1:0]    result,
    input logic                done
);
    p_eoc_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_rise |=> eoc);

    p_go_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_fall && !start_rise) |=> busy);

    p_idle_dac_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0));

    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($past(irq_en) && !eoc));

    p_result_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(result));

    p_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_rise) |=> (!busy && eoc));

    p_pwr_pin0_r11: assert property (@(posedge clk) disable iff (!rst_n)
        adc_pwr |-> ana_en[0]);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (irq_en),
    .irq_req    (irq_req),
    .eoc        (eoc),
    .start_rise (start_rise),
    .start_fall (start_fall),
    .busy       (busy),
    .dac_code   (dac_code),
    .ana_en     (ana_en),
    .adc_pwr    (adc_pwr),
    .result     (result),
    .done       (done)
);

// File: tb/sar_adc_ctrl_tb_top.sv
// Bench: sweeps levels, dividers, configuration codes and the abort path.
module sar_adc_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cmp_in;
    logic       irq_en = 1'b0;
    logic [8:0] dac_code;
    logic [1:0] ch_sel;
    logic [3:0] ana_en;
    logic       adc_pwr;
    logic       irq_req;
    logic [8:0] level = 9'd0;
    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    // Comparator model: high when the level is at or above the trial code.
    assign cmp_in = (level >= dac_code);

    sar_adc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
        .irq_en(irq_en), .dac_code(dac_code), .ch_sel(ch_sel),
        .ana_en(ana_en), .adc_pwr(adc_pwr), .irq_req(irq_req)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    // Full conversion; checks timing (R7/R8), flag and interrupt (R9),
    // result value (R6) and byte layout (R10).
    task automatic convert(input int v, input int sel, input bit test,
                           input bit ien, input string tag);
        logic [7:0] d;
        int n;
        bit irq_seen;
        level = 9'(v);
        irq_en = ien;
        wr(8'h27, {test, 5'b0, 2'(sel)});
        wr(8'h26, 8'h88);
        wr(8'h26, 8'h08);
        n = 0;
        irq_seen = 0;
        do begin
            @(posedge clk); #1;
            n++;
            rd(8'h26, d);
        end while (d[6] && n < 200);
        irq_seen = irq_req;
        check({tag, " R7 cycles"}, n, 9 * (1 << sel));
        check({tag, " R9 irq"}, int'(irq_seen), int'(ien));
        @(posedge clk); #1;
        check({tag, " R9 irq width"}, int'(irq_req), 0);
        rd(8'h25, d);
        check({tag, " R10 high byte"}, int'(d), v >> 1);
        rd(8'h24, d);
        check({tag, " R10 low byte"}, int'(d), (v & 1) << 7);
    endtask

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        for (int a = 8'h24; a <= 8'h27; a++) begin
            rd(8'(a), d);
            check("R1 reg reset", int'(d), 0);
        end
        check("R1 ana_en", int'(ana_en), 0);
        check("R1 adc_pwr", int'(adc_pwr), 0);
        check("R1 dac_code", int'(dac_code), 0);
        check("R1 irq", int'(irq_req), 0);
        // R2: unmapped reads and read-only result bytes
        wr(8'h24, 8'hFF);
        wr(8'h25, 8'hFF);
        rd(8'h24, d); check("R2 low read-only", int'(d), 0);
        rd(8'h25, d); check("R2 high read-only", int'(d), 0);
        wr(8'h28, 8'hFF);
        rd(8'h28, d); check("R2 unmapped", int'(d), 0);
        rd(8'h23, d); check("R2 unmapped", int'(d), 0);
        // R3/R4: control readback, EOC bit write ignored
        wr(8'h26, 8'h6B);
        rd(8'h26, d); check("R3 R4 ctrl readback", int'(d), 8'h2B);
        wr(8'h27, 8'hFF);
        rd(8'h27, d); check("R3 clksel readback", int'(d), 8'h83);
        wr(8'h27, 8'h00);
        // R11: all configuration codes
        for (int c = 0; c < 8; c++) begin
            int exp_en;
            exp_en = (c >= 4) ? 15 : ((1 << c) - 1);
            wr(8'h26, 8'(c << 3));
            check($sformatf("R11 ana_en cfg%0d", c), int'(ana_en), exp_en);
            check($sformatf("R11 pwr cfg%0d", c), int'(adc_pwr), int'(exp_en != 0));
        end
        // R12: channel codes, bit 2 ignored
        for (int ch = 0; ch < 8; ch++) begin
            wr(8'h26, 8'(ch));
            check($sformatf("R12 ch%0d", ch), int'(ch_sel), ch & 3);
        end
        // R4/R5: rise alone arms but does not convert
        level = 9'd300;
        wr(8'h26, 8'h88);
        rd(8'h26, d); check("R4 eoc set", int'(d[6]), 1);
        repeat (20) @(posedge clk); #1;
        check("R5 no convert dac", int'(dac_code), 0);
        rd(8'h26, d); check("R5 eoc held", int'(d[6]), 1);
        wr(8'h26, 8'h08);
        check("R5 first trial", int'(dac_code), 256);
        repeat (12) @(posedge clk); #1;
        // R6/R7/R9/R10: every level at the fastest clock
        for (int v = 0; v < 512; v++) begin
            convert(v, 0, 1'b0, 1'b1, $sformatf("R6 v%0d", v));
        end
        // R7/R8: every divider with test bit clear and set
        for (int s = 0; s < 4; s++) begin
            convert(341, s, 1'b0, 1'b1, $sformatf("R7 s%0d", s));
            convert(170, s, 1'b1, 1'b0, $sformatf("R8 s%0d", s));
        end
        // R13: abort mid-conversion, then full restart
        convert(85, 2, 1'b0, 1'b0, "R13 prior");
        irq_en = 1'b1;
        level = 9'd400;
        wr(8'h26, 8'h88);
        wr(8'h26, 8'h08);
        repeat (10) @(posedge clk); #1;
        wr(8'h26, 8'h88);
        check("R13 dac idle", int'(dac_code), 0);
        rd(8'h26, d); check("R13 eoc", int'(d[6]), 1);
        n = 0;
        repeat (40) begin
            @(posedge clk); #1;
            if (irq_req) n++;
        end
        check("R13 no irq", n, 0);
        rd(8'h25, d); check("R13 result kept", int'(d), 85 >> 1);
        rd(8'h24, d); check("R13 result kept lo", int'(d), 128);
        wr(8'h26, 8'h08);
        n = 0;
        do begin
            @(posedge clk); #1;
            n++;
            rd(8'h26, d);
        end while (d[6] && n < 200);
        check("R13 restart cycles", n, 36);
        check("R13 restart irq", int'(irq_req), 1);
        rd(8'h25, d); check("R13 restart result", int'(d), 200);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule